// File: doc/BRIEF.md
# Power Sequencer Fault Timeout and Retry Controller

This block watches over the ramp phases of a multi-rail power sequencer. Each time the sequencer begins a ramp it pulses a start strobe and gives the ramp's direction. The controller then times the phase against one of two programmable limits, one for rising ramps and one for falling ramps. If the phase does not report completion in time, the controller faults. It also faults at once when any monitored supply input reports an over- or under-voltage condition.

While a fault is active, the shutdown output forces every gate driver off and the fault output stays high. A configuration bit picks what happens next. In latch-off mode the fault holds until software issues a clear or the enable input falls. In autoretry mode the fault holds for a programmed delay, after which the block allows a new attempt. In both modes the fault is released only once every rail reports that it has discharged below the power-low level.

A two-bit cause field records why the last fault happened. All timing comes from a millisecond tick derived from the clock by a prescaler.

Top module: `seq_fault_guard`

## Requirements
- R1: After reset, fault_o is 0, cause_o is 2'b00, and retry_ok_o equals outs_low_i.
- R2: A phase started with dir_i=1 faults exactly 25<<up_to_i milliseconds (TICK_DIV clocks each) after the clock edge that samples start_i, unless it is completed first.
- R3: A phase started with dir_i=0 uses the separate field dn_to_i with the same 25<<code millisecond mapping.
- R4: A done_i sampled before or on the expiry edge ends the phase without a fault. A new start_i during a running phase restarts its timer with the full limit.
- R5: When in_fault_i is high in the idle or running state, shutdown_o rises in the same cycle and fault_o rises on the next clock edge.
- R6: cause_o holds 2'b01 after an input fault and 2'b10 after a phase timeout. When both occur on the same edge it records 2'b01. The value 2'b11 never appears.
- R7: With latch_i=1 the fault holds indefinitely. It clears only when clear_i is sampled high or enable_i falls, with the usual discharge check applied afterwards.
- R8: With latch_i=0 the fault holds for 25<<retry_i milliseconds (codes 0 to 7, 25 to 3200 ms) from the fault edge. It then releases one clock later if the rails are low.
- R9: fault_o falls only on an edge at which outs_low_i is high and in_fault_i is low. Until then, fault_o and shutdown_o stay high.
- R10: retry_ok_o is high exactly when no fault is active, no phase is running, outs_low_i is high and in_fault_i is low.
- R11: shutdown_o is high whenever fault_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Ramp phase start strobe |
| done_i | input | 1 | Ramp phase complete strobe |
| dir_i | input | 1 | Direction of the starting phase, 1 = power-up |
| in_fault_i | input | 1 | Any supply input over- or under-voltage |
| outs_low_i | input | 1 | All rails below the power-low level |
| enable_i | input | 1 | Sequencer enable; a falling edge clears a latched fault |
| clear_i | input | 1 | Clear command strobe |
| up_to_i | input | 2 | Power-up phase timeout code |
| dn_to_i | input | 2 | Power-down phase timeout code |
| latch_i | input | 1 | 1 = latch-off, 0 = autoretry |
| retry_i | input | 3 | Autoretry delay code |
| fault_o | output | 1 | Fault active |
| shutdown_o | output | 1 | Force all gates off |
| retry_ok_o | output | 1 | A new power-up attempt may start |
| cause_o | output | 2 | Cause of the last fault: 01 input, 10 timeout |

## Verification
Phase timing is tried with random directions and codes. Each phase either runs to expiry or is completed at a random point before expiry. This separates the up-timeout field from the down-timeout field, and it shows whether completion actually stops the timer. The release path is exercised with random autoretry codes, the longest code, latch-off with each clearing method, and rails held high. These cases show whether the delay is counted from the fault edge, and whether release waits for discharge. Directed edge cases cover completion on the expiry edge, a restart in mid-phase, and an input fault that coincides with expiry.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_LATCH, ST_RETRY, ST_DRAIN
  } sfg_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_INPUT   = 2'b01,
    CAUSE_TIMEOUT = 2'b10
  } sfg_cause_e;

  // duration in ms for a code: base doubled per step
  function automatic int unsigned span_ms(input int unsigned base, input logic [2:0] code);
    return base << code;
  endfunction
endpackage

// File: rtl/sfg_tick.sv
module sfg_tick #(
  parameter int unsigned TICK_DIV = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else if (en_i)        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sfg_timer.sv
module sfg_timer #(
  parameter int unsigned MS_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic [MS_W-1:0] lim_i,
  output logic            expire_o
);
  logic [MS_W-1:0] ms_q;

  assign expire_o = en_i && tick_i && (ms_q == lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ms_q <= '0;
    else if (restart_i)         ms_q <= '0;
    else if (en_i && tick_i)    ms_q <= ms_q + 1'b1;
  end
endmodule

// File: rtl/sfg_ctrl.sv
module sfg_ctrl
  import sfg_pkg::*;
#(
  parameter int unsigned BASE_MS = 25,
  parameter int unsigned MS_W    = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            done_i,
  input  logic            dir_i,
  input  logic            in_fault_i,
  input  logic            outs_low_i,
  input  logic            enable_i,
  input  logic            clear_i,
  input  logic [1:0]      up_to_i,
  input  logic [1:0]      dn_to_i,
  input  logic            latch_i,
  input  logic [2:0]      retry_i,
  input  logic            expire_i,
  output logic            restart_o,
  output logic            tmr_en_o,
  output logic [MS_W-1:0] lim_o,
  output logic            fault_o,
  output logic            shutdown_o,
  output logic            retry_ok_o,
  output logic [1:0]      cause_o
);
  sfg_state_e st_q, st_d;
  sfg_cause_e cause_q, cause_d;
  logic dir_q, dir_d, en_q, clr_evt, enter_fault;
  logic [1:0] phase_code;

  assign clr_evt    = clear_i || (en_q && !enable_i);
  assign phase_code = dir_q ? up_to_i : dn_to_i;

  always_comb begin
    if (st_q == ST_RETRY) lim_o = MS_W'(span_ms(BASE_MS, retry_i));
    else                  lim_o = MS_W'(span_ms(BASE_MS, {1'b0, phase_code}));
  end

  always_comb begin
    st_d        = st_q;
    cause_d     = cause_q;
    dir_d       = dir_q;
    restart_o   = 1'b0;
    enter_fault = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_RUN: begin
        if (in_fault_i) begin
          enter_fault = 1'b1;
          cause_d     = CAUSE_INPUT;     // input fault outranks timeout
        end else if (st_q == ST_RUN && expire_i && !done_i) begin
          enter_fault = 1'b1;
          cause_d     = CAUSE_TIMEOUT;
        end else if (start_i) begin
          st_d      = ST_RUN;
          dir_d     = dir_i;
          restart_o = 1'b1;
        end else if (st_q == ST_RUN && done_i) begin
          st_d = ST_IDLE;
        end
      end
      ST_LATCH: if (clr_evt) st_d = ST_DRAIN;
      ST_RETRY: if (clr_evt || expire_i) st_d = ST_DRAIN;
      ST_DRAIN: if (outs_low_i && !in_fault_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (enter_fault) begin
      st_d      = latch_i ? ST_LATCH : ST_RETRY;
      restart_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      dir_q   <= 1'b1;
      en_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
      dir_q   <= dir_d;
      en_q    <= enable_i;
    end
  end

  assign tmr_en_o   = (st_q == ST_RUN) || (st_q == ST_RETRY);
  assign fault_o    = (st_q == ST_LATCH) || (st_q == ST_RETRY) || (st_q == ST_DRAIN);
  assign shutdown_o = fault_o || in_fault_i;
  assign retry_ok_o = (st_q == ST_IDLE) && outs_low_i && !in_fault_i;
  assign cause_o    = cause_q;
endmodule

// File: rtl/seq_fault_guard.sv
module seq_fault_guard #(
  parameter int unsigned TICK_DIV = 125000,
  parameter int unsigned BASE_MS  = 25
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       dir_i,
  input  logic       in_fault_i,
  input  logic       outs_low_i,
  input  logic       enable_i,
  input  logic       clear_i,
  input  logic [1:0] up_to_i,
  input  logic [1:0] dn_to_i,
  input  logic       latch_i,
  input  logic [2:0] retry_i,
  output logic       fault_o,
  output logic       shutdown_o,
  output logic       retry_ok_o,
  output logic [1:0] cause_o
);
  localparam int unsigned MS_W = $clog2((BASE_MS << 7) + 1);

  logic restart, tmr_en, tick, expire;
  logic [MS_W-1:0] lim;

  sfg_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .restart_i(restart), .en_i(tmr_en), .tick_o(tick)
  );

  sfg_timer #(.MS_W(MS_W)) u_timer (
    .clk_i, .rst_ni, .restart_i(restart), .en_i(tmr_en), .tick_i(tick),
    .lim_i(lim), .expire_o(expire)
  );

  sfg_ctrl #(.BASE_MS(BASE_MS), .MS_W(MS_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .done_i, .dir_i, .in_fault_i, .outs_low_i,
    .enable_i, .clear_i, .up_to_i, .dn_to_i, .latch_i, .retry_i,
    .expire_i(expire), .restart_o(restart), .tmr_en_o(tmr_en), .lim_o(lim),
    .fault_o, .shutdown_o, .retry_ok_o, .cause_o
  );
endmodule

// File: rtl/sfg_chk.sv
module sfg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_fault_i,
  input logic       outs_low_i,
  input logic       fault_o,
  input logic       shutdown_o,
  input logic       retry_ok_o,
  input logic [1:0] cause_o
);
  // R11
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> shutdown_o);
  // R5
  input_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fault_i |-> shutdown_o);
  // R10
  permit_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_ok_o |-> (outs_low_i && !fault_o && !in_fault_i));
  // R9
  release_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> ($past(outs_low_i) && !$past(in_fault_i)));
  // R6
  cause_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o));
endmodule

bind seq_fault_guard sfg_chk u_chk (
  .clk_i, .rst_ni, .in_fault_i, .outs_low_i,
  .fault_o, .shutdown_o, .retry_ok_o, .cause_o
);

// File: tb/sim_seq_fault_guard.sv
module sim_seq_fault_guard;
  localparam int unsigned D = 4;
  localparam int unsigned BASE = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, done = 0, dir = 1, in_fault = 0, outs_low = 1;
  logic enable = 1, clear = 0, latch = 0;
  logic [1:0] up_to = 0, dn_to = 0;
  logic [2:0] retry = 0;
  logic fault, shutdown, retry_ok;
  logic [1:0] cause;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  seq_fault_guard #(.TICK_DIV(D), .BASE_MS(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_i(done), .dir_i(dir),
    .in_fault_i(in_fault), .outs_low_i(outs_low), .enable_i(enable), .clear_i(clear),
    .up_to_i(up_to), .dn_to_i(dn_to), .latch_i(latch), .retry_i(retry),
    .fault_o(fault), .shutdown_o(shutdown), .retry_ok_o(retry_ok), .cause_o(cause)
  );

  function automatic int cycles_of(input int code);
    return (BASE << code) * D;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start(input logic d);
    dir = d; start = 1; @(posedge clk); @(negedge clk); start = 0;
  endtask

  task automatic pulse_clear();
    clear = 1; @(posedge clk); @(negedge clk); clear = 0;
  endtask

  task automatic recover();
    latch = 0; retry = 0; outs_low = 1; in_fault = 0; enable = 1;
    for (int k = 0; k < 3000 && fault; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fault", fault, 0);
    chk("R1 cause", cause, 0);
    chk("R1 retry_ok", retry_ok, 1);
    outs_low = 0; #1 chk("R1 retry_ok follows low", retry_ok, 0); outs_low = 1;
    @(negedge clk);

    // random phases: expiry or early completion
    for (int i = 0; i < 8; i++) begin
      automatic logic d = 1'($urandom % 2);
      automatic int code = $urandom % 4;
      automatic int rc = $urandom % 4;
      automatic int early = $urandom % 2;
      automatic int l = cycles_of(code);
      automatic int r = cycles_of(rc);
      up_to = d ? 2'(code) : 2'(3 - code);
      dn_to = d ? 2'(3 - code) : 2'(code);
      retry = 3'(rc); latch = 0;
      pulse_start(d);
      if (early != 0) begin
        automatic int k = 1 + ($urandom % (l - 1));
        repeat (k - 1) @(posedge clk);
        @(negedge clk); done = 1; @(posedge clk); @(negedge clk); done = 0;
        repeat (l) @(posedge clk);
        @(negedge clk);
        chk("R4 done early no fault", fault, 0);
        chk("R10 permit after done", retry_ok, 1);
      end else begin
        repeat (l - 1) @(posedge clk);
        @(negedge clk);
        chk(d ? "R2 before expiry" : "R3 before expiry", fault, 0);
        @(posedge clk); @(negedge clk);
        chk(d ? "R2 at expiry" : "R3 at expiry", fault, 1);
        chk("R6 timeout cause", cause, 2);
        chk("R11 shutdown", shutdown, 1);
        chk("R10 no permit in fault", retry_ok, 0);
        repeat (r) @(posedge clk);
        @(negedge clk);
        chk("R8 held to delay end", fault, 1);
        @(posedge clk); @(negedge clk);
        chk("R8 released", fault, 0);
      end
    end

    // R4 done on the expiry edge wins
    up_to = 0; pulse_start(1);
    repeat (cycles_of(0) - 1) @(posedge clk);
    @(negedge clk); done = 1; @(posedge clk); @(negedge clk); done = 0;
    chk("R4 done on expiry edge", fault, 0);
    repeat (20) @(negedge clk);
    chk("R4 stays idle", fault, 0);

    // R4 restart mid-phase
    pulse_start(1);
    repeat (49) @(posedge clk);
    @(negedge clk); pulse_start(1);
    repeat (cycles_of(0) - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 restarted timer", fault, 0);
    @(posedge clk); @(negedge clk);
    chk("R4 restart expiry", fault, 1);
    recover();

    // R5 immediate shutdown, registered fault
    in_fault = 1; #1;
    chk("R5 shutdown same cycle", shutdown, 1);
    chk("R5 fault not yet", fault, 0);
    chk("R10 permit drops", retry_ok, 0);
    @(posedge clk); @(negedge clk); in_fault = 0;
    chk("R5 fault next edge", fault, 1);
    chk("R6 input cause", cause, 1);
    recover();

    // R6 simultaneous input fault and expiry
    dn_to = 1; pulse_start(0);
    repeat (cycles_of(1) - 1) @(posedge clk);
    @(negedge clk); in_fault = 1; @(posedge clk); @(negedge clk); in_fault = 0;
    chk("R6 tie fault", fault, 1);
    chk("R6 tie cause input", cause, 1);
    recover();

    // R7 latch-off, cleared by command
    latch = 1; in_fault = 1; @(posedge clk); @(negedge clk); in_fault = 0;
    repeat (2000) @(negedge clk);
    chk("R7 latched", fault, 1);
    pulse_clear();
    chk("R7 drain step", fault, 1);
    @(posedge clk); @(negedge clk);
    chk("R7 clear releases", fault, 0);
    // R7 latch-off, cleared by enable falling
    in_fault = 1; @(posedge clk); @(negedge clk); in_fault = 0;
    repeat (600) @(negedge clk);
    chk("R7 latched again", fault, 1);
    enable = 0; @(posedge clk); @(negedge clk);
    chk("R7 drain step enable", fault, 1);
    @(posedge clk); @(negedge clk);
    chk("R7 enable fall releases", fault, 0);
    enable = 1;
    recover();

    // R9 rails not discharged hold the fault
    retry = 0; outs_low = 0;
    in_fault = 1; @(posedge clk); @(negedge clk); in_fault = 0;
    repeat (cycles_of(0) + 20) @(negedge clk);
    chk("R9 held while rails high", fault, 1);
    chk("R9 shutdown held", shutdown, 1);
    chk("R10 no permit rails high", retry_ok, 0);
    outs_low = 1; @(posedge clk); @(negedge clk);
    chk("R9 release after discharge", fault, 0);
    chk("R10 permit after release", retry_ok, 1);

    // R8 longest autoretry code
    retry = 7;
    in_fault = 1; @(posedge clk); @(negedge clk); in_fault = 0;
    repeat (cycles_of(7)) @(posedge clk);
    @(negedge clk);
    chk("R8 code7 held", fault, 1);
    @(posedge clk); @(negedge clk);
    chk("R8 code7 released", fault, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule